// File: doc/BRIEF.md
# UART Receive Queue and Status Flags

This block is the receive half of one serial channel. It sits behind a bit-level deserializer that has already assembled each frame. Each completed frame arrives as a data byte and its stop-bit value. Ordinary characters go into a three-entry queue that the processor drains through a read strobe. When the queue is full, one more character can wait in a single hold slot, which stands in for the receive shift register. The hold slot empties into the queue as soon as a read frees an entry. If a character arrives while both the queue and the hold slot are occupied, it is dropped and a sticky overrun flag is raised.

A ready flag reports one of two meanings, chosen by a mode bit. In one mode it means "data available". In the other it means "a transfer has just filled the queue". A frame with all-zero data and a zero stop bit marks the start of a line break. The first return of the serial line to the mark level after that frame marks the end of the break. Both the start and the end latch a break-change flag, which only a command strobe clears. An interrupt output combines the ready flag and the break-change flag through two enable bits.

Top module: `rxq_top`

## Requirements
- R1: After reset, rdData is zero, and readyFlag, breakChange, overrun and irq are all low.
- R2: The queue holds up to three characters. A read (rdStrobe high while the queue is non-empty) puts the oldest stored character on rdData. Characters come out in the order they arrived.
- R3: With readyMode = 0, readyFlag is high exactly when the queue holds at least one character. It stays high after a read that leaves characters behind.
- R4: With readyMode = 1, readyFlag sets when a write into the queue brings it to three entries. It clears on a read of a non-empty queue, unless the same cycle's write refills the queue to three.
- R5: A character that completes while the queue is full waits in the hold slot. It enters the queue in the cycle of the next read, and with readyMode = 1 this raises readyFlag again.
- R6: A character that completes while the queue is full and the hold slot is occupied is discarded and sets overrun. Overrun stays high until cmdResetError. A new overrun in the same cycle as the command wins.
- R7: A frame with charData = 0 and stopBit = 0 is a break start. It is not stored, and it sets breakChange. While a break is active, further break frames are ignored. The first cycle with rxLine = 1 ends the break and sets breakChange again.
- R8: breakChange clears only on cmdResetBreak. A break edge in the same cycle as the command keeps it set.
- R9: irq is high when irqMask[0] is set and readyFlag is high, or when irqMask[1] is set and breakChange is high.
- R10: A read while the queue is empty leaves rdData and every flag unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| charValid | input | 1 | Deserializer has completed a frame this cycle |
| charData | input | DATA_W | Data bits of the completed frame |
| stopBit | input | 1 | Sampled stop bit of the completed frame |
| rxLine | input | 1 | Current serial line level (1 = mark) |
| rdStrobe | input | 1 | Processor read of the receive buffer |
| readyMode | input | 1 | 0: ready means data available; 1: ready means queue filled |
| cmdResetBreak | input | 1 | Command strobe clearing breakChange |
| cmdResetError | input | 1 | Command strobe clearing overrun |
| irqMask | input | 2 | Bit 0 enables the ready interrupt, bit 1 the break-change interrupt |
| rdData | output | DATA_W | Character returned by the last read of a non-empty queue |
| readyFlag | output | 1 | Ready flag in the selected meaning |
| breakChange | output | 1 | Break start or end has been seen |
| overrun | output | 1 | A character was lost |
| irq | output | 1 | Masked interrupt request |

## Verification
Every state change lands in registers on the clock edge where its stimulus is sampled. rdData, overrun, breakChange and the queue-derived readyFlag therefore move exactly one edge after the input cycle. readyFlag's mode selection and irq's masking follow readyMode and irqMask in the same cycle, with no edge between them. The bench drives inputs shortly after a rising edge. A behavioural model, built from a queue and a few flags, updates on the same edge as the design. The bench compares all five outputs a short delay after every edge, so each result is checked in the cycle it is due. The directed sequences cover queue fill, the hold slot, overrun, break start and end, command collisions and empty reads. A long random run follows them.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Strobes the control side hands to the datapath each cycle
  typedef struct packed {
    logic push;          // write one entry into the queue
    logic pushFromHold;  // the written entry comes from the hold slot
    logic holdLoad;      // capture the incoming character into the hold slot
    logic pop;           // advance the read side and update rdData
  } rxqStrobes_t;

endpackage

// File: rtl/rxq_brk.sv
module rxq_brk #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              charValid,
  input  logic [DATA_W-1:0] charData,
  input  logic              stopBit,
  input  logic              rxLine,
  input  logic              cmdResetBreak,
  output logic              breakFrame,
  output logic              breakChange
);

  logic inBreak;
  logic breakStart;
  logic breakEnd;

  // A zero frame with a missing stop bit is a break
  assign breakFrame = charValid && (charData == '0) && !stopBit;
  assign breakStart = breakFrame && !inBreak;
  assign breakEnd   = inBreak && rxLine;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inBreak <= 1'b0;
    end else if (breakStart) begin
      inBreak <= 1'b1;
    end else if (breakEnd) begin
      inBreak <= 1'b0;
    end
  end

  // Either edge of the break sets the flag; an edge wins over the command
  always_ff @(posedge clk) begin
    if (!rstN) begin
      breakChange <= 1'b0;
    end else if (breakStart || breakEnd) begin
      breakChange <= 1'b1;
    end else if (cmdResetBreak) begin
      breakChange <= 1'b0;
    end
  end

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        charValid,
  input  logic        breakFrame,
  input  logic        rdStrobe,
  input  logic        readyMode,
  input  logic        cmdResetError,
  output rxqStrobes_t stb,
  output logic        readyFlag,
  output logic        overrun
);

  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] countNxt;
  logic             holdValid;
  logic             holdValidNxt;
  logic             fullEvt;
  logic             overrunSet;
  logic             isEmpty;
  logic             isFull;
  logic             popOk;
  logic             roomAfterPop;
  logic             normalChar;

  assign isEmpty      = (count == '0);
  assign isFull       = (count == CNT_FULL);
  assign popOk        = rdStrobe && !isEmpty;
  assign roomAfterPop = !isFull || popOk;
  assign normalChar   = charValid && !breakFrame;

  // One queue write per cycle: the hold slot drains first, and a new
  // character then takes over the slot it left behind
  always_comb begin
    stb          = '0;
    stb.pop      = popOk;
    holdValidNxt = holdValid;
    overrunSet   = 1'b0;
    if (holdValid && roomAfterPop) begin
      stb.push         = 1'b1;
      stb.pushFromHold = 1'b1;
      holdValidNxt     = 1'b0;
    end
    if (normalChar) begin
      if (holdValid) begin
        if (roomAfterPop) begin
          stb.holdLoad = 1'b1;
          holdValidNxt = 1'b1;
        end else begin
          overrunSet = 1'b1;
        end
      end else if (roomAfterPop) begin
        stb.push = 1'b1;
      end else begin
        stb.holdLoad = 1'b1;
        holdValidNxt = 1'b1;
      end
    end
  end

  assign countNxt = count + {{(CNT_W-1){1'b0}}, stb.push}
                          - {{(CNT_W-1){1'b0}}, stb.pop};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      holdValid <= 1'b0;
    end else begin
      count     <= countNxt;
      holdValid <= holdValidNxt;
    end
  end

  // Full event: raised by a write that completes the queue, dropped by a read
  always_ff @(posedge clk) begin
    if (!rstN) begin
      fullEvt <= 1'b0;
    end else if (stb.push && (countNxt == CNT_FULL)) begin
      fullEvt <= 1'b1;
    end else if (popOk) begin
      fullEvt <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      overrun <= 1'b0;
    end else if (overrunSet) begin
      overrun <= 1'b1;
    end else if (cmdResetError) begin
      overrun <= 1'b0;
    end
  end

  assign readyFlag = readyMode ? fullEvt : !isEmpty;

endmodule

// File: rtl/rxq_dpath.sv
module rxq_dpath
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  rxqStrobes_t       stb,
  input  logic [DATA_W-1:0] charData,
  output logic [DATA_W-1:0] rdData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] holdData;
  logic [DATA_W-1:0] wrData;
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  assign wrData = stb.pushFromHold ? holdData : charData;

  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    always_ff @(posedge clk) begin
      if (stb.push && (wrPtr == PTR_W'(i))) begin
        mem[i] <= wrData;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (stb.holdLoad) begin
      holdData <= charData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      rdData <= '0;
    end else begin
      if (stb.push) begin
        wrPtr <= bump(wrPtr);
      end
      if (stb.pop) begin
        rdPtr  <= bump(rdPtr);
        rdData <= mem[rdPtr];
      end
    end
  end

endmodule

// File: rtl/rxq_top.sv
module rxq_top
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              charValid,
  input  logic [DATA_W-1:0] charData,
  input  logic              stopBit,
  input  logic              rxLine,
  input  logic              rdStrobe,
  input  logic              readyMode,
  input  logic              cmdResetBreak,
  input  logic              cmdResetError,
  input  logic [1:0]        irqMask,
  output logic [DATA_W-1:0] rdData,
  output logic              readyFlag,
  output logic              breakChange,
  output logic              overrun,
  output logic              irq
);

  rxqStrobes_t stb;
  logic        breakFrame;

  rxq_brk #(.DATA_W(DATA_W)) uBrk (
    .clk           (clk),
    .rstN          (rstN),
    .charValid     (charValid),
    .charData      (charData),
    .stopBit       (stopBit),
    .rxLine        (rxLine),
    .cmdResetBreak (cmdResetBreak),
    .breakFrame    (breakFrame),
    .breakChange   (breakChange)
  );

  rxq_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .charValid     (charValid),
    .breakFrame    (breakFrame),
    .rdStrobe      (rdStrobe),
    .readyMode     (readyMode),
    .cmdResetError (cmdResetError),
    .stb           (stb),
    .readyFlag     (readyFlag),
    .overrun       (overrun)
  );

  rxq_dpath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .charData (charData),
    .rdData   (rdData)
  );

  assign irq = (irqMask[0] && readyFlag) || (irqMask[1] && breakChange);

endmodule

// File: rtl/rxq_chk.sv
module rxq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              charValid,
  input logic              rdStrobe,
  input logic              readyMode,
  input logic              cmdResetBreak,
  input logic              cmdResetError,
  input logic [1:0]        irqMask,
  input logic [DATA_W-1:0] rdData,
  input logic              readyFlag,
  input logic              breakChange,
  input logic              overrun,
  input logic              irq
);

  // R6
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !cmdResetError |=> overrun);

  // R6
  overrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    !overrun && !charValid |=> !overrun);

  // R8
  brk_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    breakChange && !cmdResetBreak |=> breakChange);

  // R10
  empty_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !readyMode && !readyFlag && rdStrobe |=> $stable(rdData));

  // R3
  avail_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !readyMode && readyFlag && !rdStrobe |=> (readyMode || readyFlag));

  // R4
  full_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    readyMode && !readyFlag && !charValid && !rdStrobe |=> (!readyMode || !readyFlag));

  // R9
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqMask == 2'b00) |-> !irq);

endmodule

bind rxq_top rxq_chk #(.DATA_W(DATA_W)) uChk (
  .clk           (clk),
  .rstN          (rstN),
  .charValid     (charValid),
  .rdStrobe      (rdStrobe),
  .readyMode     (readyMode),
  .cmdResetBreak (cmdResetBreak),
  .cmdResetError (cmdResetError),
  .irqMask       (irqMask),
  .rdData        (rdData),
  .readyFlag     (readyFlag),
  .breakChange   (breakChange),
  .overrun       (overrun),
  .irq           (irq)
);

// File: tb/test_rxq_top.sv
`timescale 1ns/1ps
module test_rxq_top;

  localparam int DATA_W = 8;
  localparam int DEPTH  = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              charValid = 1'b0;
  logic [DATA_W-1:0] charData = '0;
  logic              stopBit = 1'b1;
  logic              rxLine = 1'b1;
  logic              rdStrobe = 1'b0;
  logic              readyMode = 1'b0;
  logic              cmdResetBreak = 1'b0;
  logic              cmdResetError = 1'b0;
  logic [1:0]        irqMask = 2'b00;
  logic [DATA_W-1:0] rdData;
  logic              readyFlag;
  logic              breakChange;
  logic              overrun;
  logic              irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  rxq_top #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_rxq_top (
    .clk           (clk),
    .rstN          (rstN),
    .charValid     (charValid),
    .charData      (charData),
    .stopBit       (stopBit),
    .rxLine        (rxLine),
    .rdStrobe      (rdStrobe),
    .readyMode     (readyMode),
    .cmdResetBreak (cmdResetBreak),
    .cmdResetError (cmdResetError),
    .irqMask       (irqMask),
    .rdData        (rdData),
    .readyFlag     (readyFlag),
    .breakChange   (breakChange),
    .overrun       (overrun),
    .irq           (irq)
  );

  // Behavioural reference model
  logic [DATA_W-1:0] mQ[$];
  logic [DATA_W-1:0] mRd;
  logic [DATA_W-1:0] mHold;
  bit mHoldV, mFull, mOvr, mBrk, mInBrk;

  always @(posedge clk) begin
    bit popOk, pushed, isBrk;
    if (!rstN) begin
      mQ.delete();
      mRd = '0; mHold = '0;
      mHoldV = 0; mFull = 0; mOvr = 0; mBrk = 0; mInBrk = 0;
    end else begin
      popOk  = rdStrobe && (mQ.size() > 0);
      pushed = 0;
      isBrk  = charValid && (charData == '0) && !stopBit;
      if (popOk) mRd = mQ.pop_front();
      if (mHoldV && mQ.size() < DEPTH) begin
        mQ.push_back(mHold);
        mHoldV = 0;
        pushed = 1;
      end
      if (cmdResetError) mOvr = 0;
      if (charValid && !isBrk) begin
        if (mQ.size() < DEPTH) begin
          mQ.push_back(charData);
          pushed = 1;
        end else if (!mHoldV) begin
          mHold  = charData;
          mHoldV = 1;
        end else begin
          mOvr = 1;
        end
      end
      if (pushed && mQ.size() == DEPTH) mFull = 1;
      else if (popOk) mFull = 0;
      if (cmdResetBreak) mBrk = 0;
      if (isBrk && !mInBrk) begin
        mInBrk = 1; mBrk = 1;
      end else if (mInBrk && rxLine) begin
        mInBrk = 0; mBrk = 1;
      end
    end
  end

  task automatic check1(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    bit expReady;
    expReady = readyMode ? mFull : (mQ.size() != 0);
    check1("R2 R10 rdData", rdData, mRd);
    check1(readyMode ? "R4 R5 readyFlag" : "R3 readyFlag", readyFlag, expReady);
    check1("R6 overrun", overrun, mOvr);
    check1("R7 R8 breakChange", breakChange, mBrk);
    check1("R9 irq", irq, (irqMask[0] && expReady) || (irqMask[1] && mBrk));
  endtask

  // Advance one edge, compare, then release single-cycle strobes
  task automatic tick();
    @(posedge clk);
    #2;
    if (rstN) compareAll();
    charValid = 0; rdStrobe = 0; cmdResetBreak = 0; cmdResetError = 0;
    stopBit = 1;
  endtask

  task automatic sendChar(input logic [DATA_W-1:0] d);
    charValid = 1; charData = d; stopBit = 1;
    tick();
  endtask

  task automatic readBuf();
    rdStrobe = 1;
    tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic drainAll();
    for (int i = 0; i < 5; i++) readBuf();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    rstN = 1;
    // R1 reset state
    check1("R1 rdData", rdData, 0);
    check1("R1 readyFlag", readyFlag, 0);
    check1("R1 breakChange", breakChange, 0);
    check1("R1 overrun", overrun, 0);
    check1("R1 irq", irq, 0);
    irqMask = 2'b01;

    // R10 empty read, then R2/R3 ordering in available mode
    readBuf();
    sendChar(8'h11); sendChar(8'h22);
    readBuf(); idle(1); readBuf(); readBuf();

    // R5/R6 fill, hold slot, overrun, error reset
    sendChar(8'h31); sendChar(8'h32); sendChar(8'h33);
    sendChar(8'h34); sendChar(8'h35);
    cmdResetError = 1; charValid = 1; charData = 8'h36; tick();  // set wins
    cmdResetError = 1; tick();
    readBuf(); idle(1); drainAll();

    // R4/R5 full mode: fill, hold, read refills, empty read
    readyMode = 1;
    sendChar(8'h41); sendChar(8'h42); sendChar(8'h43); sendChar(8'h44);
    readBuf(); idle(1); readBuf(); idle(1);
    rdStrobe = 1; charValid = 1; charData = 8'h45; tick();
    drainAll(); readBuf();
    readyMode = 0; idle(1);

    // R7/R8 break start and end, command collisions
    irqMask = 2'b10;
    rxLine = 0; charValid = 1; charData = 0; stopBit = 0; tick();
    charValid = 1; charData = 0; stopBit = 0; tick();
    cmdResetBreak = 1; tick();
    idle(1);
    rxLine = 1; cmdResetBreak = 1; tick();
    cmdResetBreak = 1; tick();
    sendChar(8'h00); readBuf();
    irqMask = 2'b11; idle(1);

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      charValid = (r < 40);
      charData  = (r < 8) ? 8'h00 : DATA_W'($urandom);
      stopBit   = (r >= 5);
      rxLine    = ($urandom_range(0, 9) != 0);
      rdStrobe  = ($urandom_range(0, 99) < 35);
      cmdResetBreak = ($urandom_range(0, 19) == 0);
      cmdResetError = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 99) == 0) readyMode = ~readyMode;
      if ($urandom_range(0, 49) == 0) irqMask = 2'($urandom);
      tick();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule